// File: doc/BRIEF.md
# Display Timing Generator

This block drives the raster timing of a display output from the pixel clock. It produces horizontal sync, vertical sync and data enable, and it reports the column and row of the current active pixel so that downstream logic can fetch pixel data. Every interval of the raster can be programmed: the active size, the sync pulse widths, the back and front porches and the active level of each of the three control outputs. The registers come out of reset with a working default mode.

The frame period can also be held to a target. The pixel clock often cannot be set to exactly the frequency a display expects. The target is therefore given as the total number of pixel clocks one frame must last. When that target is longer than the natural raster, the surplus clocks are added to the front porch of the last line of each frame only, and all other lines keep their programmed length. Writes land in a staging register set. The generator copies that set into its working set while it is disabled and at each frame boundary, so a frame never mixes two configurations.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset, hsync and vsync are high, de is low, and pix_x and line_y are zero.
- R2: While enable is low, every control output sits at its inactive level for the configured polarity, and both counters read zero. A polarity written while disabled takes effect on the idle outputs within two clocks.
- R3: Each line is the sync pulse (HSYNC_W clocks, starting at the first clock of the line), then the back porch (HBP clocks), then HACT clocks with de active, then the front porch (HFP clocks).
- R4: Each frame is VSYNC_W lines with vsync active, then VBP lines, then VACT lines that carry de, then VFP lines. The frame period is the line length times the line count.
- R5: While de is active, pix_x counts 0 to HACT-1 along a line and line_y counts 0 to VACT-1 down the frame. Both read 0 whenever de is inactive.
- R6: Configuration select codes are: 0 HACT, 1 HSYNC_W, 2 HBP, 3 HFP, 4 VACT, 5 VSYNC_W, 6 VBP, 7 VFP, 8 polarity, 9 frame target. In the polarity word, bit 0 is hsync, bit 1 is vsync and bit 2 is de, and a 1 means active high.
- R7: The reset configuration is 1280x640 active, hsync 40, horizontal porches 50/50, vsync 20 lines, vertical back porch 31 and front porch 30. Hsync and vsync are active low and de is active high. The frame target corresponds to 60 frames per second at a 61.15 MHz pixel clock.
- R8: When the frame target T exceeds the natural frame length N, the last line of each frame is T-N clocks longer. The extra clocks fall in its front porch, and the frame period equals T.
- R9: When T is not larger than N, no line is lengthened and the frame period is N.
- R10: A configuration write made while the generator runs leaves the current frame unchanged and applies from the next frame.
- R11: Clearing enable forces the outputs inactive at the next clock. Setting it again restarts the raster at line 0, pixel 0, with the sync pulses active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the raster when high |
| cfg_we | input | 1 | Write strobe for the staging registers |
| cfg_sel | input | 4 | Register select code (R6) |
| cfg_wdata | input | TW (32) | Write data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_x | output | HW (12) | Column of the active pixel |
| line_y | output | VW (12) | Row of the active pixel |

## Verification
The embedded properties assume a sane raster. The total line and frame lengths must be at least one. The natural frame length must fit in the target width. A configuration write must never be issued in the cycle that wraps a frame. The directed scenarios use small rasters whose totals are far from zero, plus the reset mode. They place every running-time write in the middle of a line, well clear of a frame edge. Enable changes and polarity writes are made only between samples, so each one has a defined effective edge.

// File: rtl/disp_timing_gen.sv
module disp_timing_gen #(
  parameter int HW = 12,
  parameter int VW = 12,
  parameter int TW = 32,
  parameter int DEF_HACT = 1280,
  parameter int DEF_HSYNC = 40,
  parameter int DEF_HBP = 50,
  parameter int DEF_HFP = 50,
  parameter int DEF_VACT = 640,
  parameter int DEF_VSYNC = 20,
  parameter int DEF_VBP = 31,
  parameter int DEF_VFP = 30,
  parameter logic [2:0] DEF_POL = 3'b100,
  parameter int PCLK_KHZ = 61150,
  parameter int DEF_FPS = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_sel,
  input  logic [TW-1:0] cfg_wdata,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [HW-1:0] pix_x,
  output logic [VW-1:0] line_y
);
  localparam int HTW = HW + 2;
  localparam int VTW = VW + 2;
  localparam int PW = HTW + VTW;
  localparam int MW = (PW > TW) ? PW : TW;
  localparam longint TGT_L = longint'(PCLK_KHZ) * 64'd1000 / longint'(DEF_FPS);
  localparam logic [TW-1:0] DEF_TGT = TW'(TGT_L);

  // index 0 active, 1 sync, 2 back porch, 3 front porch
  logic [HW-1:0] s_h [4];
  logic [HW-1:0] a_h [4];
  logic [VW-1:0] s_v [4];
  logic [VW-1:0] a_v [4];
  logic [2:0]    s_pol, a_pol;
  logic [TW-1:0] s_tgt, a_tgt;

  logic           run;
  logic [TW-1:0]  hc;
  logic [VTW-1:0] vc;

  logic [HTW-1:0] hstart, hstop, htot;
  logic [VTW-1:0] vstart, vstop, vtot;
  logic [PW-1:0]  nat;
  logic [MW-1:0]  extra_m;
  logic [TW-1:0]  extra, hend;
  logic           last_line, h_wrap, f_wrap;
  logic           hs_on, vs_on, h_act, v_act, de_on;

  assign hstart = HTW'(a_h[1]) + HTW'(a_h[2]);
  assign hstop  = hstart + HTW'(a_h[0]);
  assign htot   = hstop + HTW'(a_h[3]);
  assign vstart = VTW'(a_v[1]) + VTW'(a_v[2]);
  assign vstop  = vstart + VTW'(a_v[0]);
  assign vtot   = vstop + VTW'(a_v[3]);

  assign nat     = PW'(htot) * PW'(vtot);
  assign extra_m = (MW'(a_tgt) > MW'(nat)) ? MW'(a_tgt) - MW'(nat) : '0;
  assign extra   = TW'(extra_m);

  assign last_line = (vc == vtot - VTW'(1));
  assign hend      = TW'(htot) - TW'(1) + (last_line ? extra : '0);
  assign h_wrap    = (hc == hend);
  assign f_wrap    = h_wrap && last_line;

  assign hs_on = hc < TW'(a_h[1]);
  assign vs_on = vc < VTW'(a_v[1]);
  assign h_act = (hc >= TW'(hstart)) && (hc < TW'(hstop));
  assign v_act = (vc >= vstart) && (vc < vstop);
  assign de_on = run && h_act && v_act;

  assign hsync  = ~((run && hs_on) ^ a_pol[0]);
  assign vsync  = ~((run && vs_on) ^ a_pol[1]);
  assign de     = ~(de_on ^ a_pol[2]);
  assign pix_x  = de_on ? HW'(hc - TW'(hstart)) : '0;
  assign line_y = de_on ? VW'(vc - vstart) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_h[0] <= HW'(DEF_HACT);  s_h[1] <= HW'(DEF_HSYNC);
      s_h[2] <= HW'(DEF_HBP);   s_h[3] <= HW'(DEF_HFP);
      s_v[0] <= VW'(DEF_VACT);  s_v[1] <= VW'(DEF_VSYNC);
      s_v[2] <= VW'(DEF_VBP);   s_v[3] <= VW'(DEF_VFP);
      a_h[0] <= HW'(DEF_HACT);  a_h[1] <= HW'(DEF_HSYNC);
      a_h[2] <= HW'(DEF_HBP);   a_h[3] <= HW'(DEF_HFP);
      a_v[0] <= VW'(DEF_VACT);  a_v[1] <= VW'(DEF_VSYNC);
      a_v[2] <= VW'(DEF_VBP);   a_v[3] <= VW'(DEF_VFP);
      s_pol <= DEF_POL;
      a_pol <= DEF_POL;
      s_tgt <= DEF_TGT;
      a_tgt <= DEF_TGT;
      run   <= 1'b0;
      hc    <= '0;
      vc    <= '0;
    end else begin
      if (cfg_we) begin
        case (cfg_sel)
          4'd0, 4'd1, 4'd2, 4'd3: s_h[cfg_sel[1:0]] <= HW'(cfg_wdata);
          4'd4, 4'd5, 4'd6, 4'd7: s_v[cfg_sel[1:0]] <= VW'(cfg_wdata);
          4'd8: s_pol <= cfg_wdata[2:0];
          4'd9: s_tgt <= cfg_wdata;
          default: ;
        endcase
      end
      run <= enable;
      if (!run || f_wrap) begin
        a_h   <= s_h;
        a_v   <= s_v;
        a_pol <= s_pol;
        a_tgt <= s_tgt;
      end
      if (!enable || !run) begin
        hc <= '0;
        vc <= '0;
      end else if (h_wrap) begin
        hc <= '0;
        vc <= last_line ? '0 : vc + VTW'(1);
      end else begin
        hc <= hc + TW'(1);
      end
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (hsync == ~a_pol[0] && vsync == ~a_pol[1] && de == ~a_pol[2]
              && pix_x == '0 && line_y == '0));

  assert_de_outside_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    de_on |-> (!hs_on && !vs_on));

  assert_pix_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $past(de_on) && de_on && !$past(h_wrap))
      |-> pix_x == HW'($past(pix_x) + 1'b1));

  assert_line_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> hc <= hend);

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(f_wrap))
      |-> ($stable(a_h[0]) && $stable(a_v[0]) && $stable(a_pol) && $stable(a_tgt)));

  assert_restart_origin_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (hc == '0 && vc == '0));
endmodule

// File: tb/test_disp_timing_gen.sv
module test_disp_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        hsync, vsync, de;
  logic [11:0] pix_x, line_y;

  disp_timing_gen i_disp_timing_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .hsync(hsync), .vsync(vsync),
    .de(de), .pix_x(pix_x), .line_y(line_y));

  always #5 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  longint b_h[4] = '{1280, 40, 50, 50};
  longint b_v[4] = '{640, 20, 31, 30};
  logic [2:0] b_pol = 3'b100;
  longint b_tgt = 64'd61150 * 1000 / 60;
  longint c_h[4], c_v[4], c_tgt;
  logic [2:0] c_pol;
  bit m_run = 0;
  longint m_h = 0, m_v = 0, cyc = 0;
  int mm, de_cnt, hs_cnt;
  longint last_rise, period, first_mm;
  bit prev_vs;

  task automatic load_cfg();
    c_h = b_h; c_v = b_v; c_pol = b_pol; c_tgt = b_tgt;
  endtask

  task automatic chk(string req, longint act, longint exp, string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic begin_sc();
    mm = 0; de_cnt = 0; hs_cnt = 0; last_rise = -1; period = 0; prev_vs = 0; first_mm = -1;
  endtask

  task automatic step();
    longint htot, vtot, nat, extra, hend, hs0, vs0;
    bit hon, von, de_on, vs_now;
    logic hs_e, vs_e, de_e;
    logic [11:0] x_e, y_e;
    @(negedge clk);
    cyc++;
    hs0 = c_h[1] + c_h[2];
    vs0 = c_v[1] + c_v[2];
    htot = hs0 + c_h[0] + c_h[3];
    vtot = vs0 + c_v[0] + c_v[3];
    nat = htot * vtot;
    extra = (c_tgt > nat) ? c_tgt - nat : 0;
    hend = (m_v == vtot - 1) ? htot - 1 + extra : htot - 1;
    hon = (m_h >= hs0) && (m_h < hs0 + c_h[0]);
    von = (m_v >= vs0) && (m_v < vs0 + c_v[0]);
    de_on = m_run && hon && von;
    hs_e = (m_run && m_h < c_h[1]) ? c_pol[0] : !c_pol[0];
    vs_e = (m_run && m_v < c_v[1]) ? c_pol[1] : !c_pol[1];
    de_e = de_on ? c_pol[2] : !c_pol[2];
    x_e = de_on ? 12'(m_h - hs0) : 12'd0;
    y_e = de_on ? 12'(m_v - vs0) : 12'd0;
    if (hsync !== hs_e || vsync !== vs_e || de !== de_e || pix_x !== x_e || line_y !== y_e) begin
      mm++;
      if (first_mm < 0) first_mm = cyc;
    end
    if (hsync === c_pol[0]) hs_cnt++;
    if (de === c_pol[2]) de_cnt++;
    vs_now = (vsync === c_pol[1]);
    if (vs_now && !prev_vs) begin
      if (last_rise >= 0) period = cyc - last_rise;
      last_rise = cyc;
    end
    prev_vs = vs_now;
    if (!m_run) load_cfg();
    else if (m_h == hend) begin
      m_h = 0;
      if (m_v == vtot - 1) begin m_v = 0; load_cfg(); end
      else m_v++;
    end else m_h++;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic report_mm(string req);
    chk(req, mm, 0, "cycles diverging from expected raster");
    if (mm != 0) $display("  first divergence at cycle %0d", first_mm);
  endtask

  task automatic wr(int sel, longint val);
    cfg_sel = 4'(sel); cfg_wdata = 32'(val); cfg_we = 1'b1;
    if (sel < 4) b_h[sel] = val;
    else if (sel < 8) b_v[sel-4] = val;
    else if (sel == 8) b_pol = 3'(val);
    else b_tgt = val;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic set_en(bit b);
    enable = b;
    if (b && !m_run) begin m_run = 1; m_h = 0; m_v = 0; load_cfg(); end
    if (!b) m_run = 0;
  endtask

  task automatic cfg_small(longint tgt);
    wr(0, 8); wr(1, 2); wr(2, 3); wr(3, 4);
    wr(4, 4); wr(5, 1); wr(6, 2); wr(7, 1);
    wr(8, 4); wr(9, tgt);
    steps(2);
  endtask

  task automatic t_reset();
    chk("R1", hsync, 1, "hsync after reset");
    chk("R1", vsync, 1, "vsync after reset");
    chk("R1", de, 0, "de after reset");
    chk("R1", pix_x + line_y, 0, "counters after reset");
  endtask

  task automatic t_defaults();
    begin_sc();
    set_en(1);
    steps(3 * 1420);
    report_mm("R7");
    chk("R7", hs_cnt, 120, "hsync active clocks in 3 default lines");
    chk("R7", de_cnt, 0, "de clocks inside default vertical blanking");
    set_en(0);
    steps(3);
  endtask

  task automatic t_raster();
    begin_sc();
    cfg_small(0);
    set_en(1);
    steps(58);
    step();
    chk("R5", pix_x, 2, "pix_x at line 3 clock 7");
    chk("R5", line_y, 0, "line_y at first active line");
    steps(3 * 136 - 59);
    report_mm("R3");
    chk("R3", hs_cnt, 48, "hsync active clocks over 3 frames");
    chk("R4", period, 136, "frame period");
    chk("R5", de_cnt, 96, "de clocks over 3 frames");
    set_en(0);
    steps(3);
  endtask

  task automatic t_polarity();
    begin_sc();
    wr(8, 3);
    steps(2);
    chk("R2", hsync, 0, "idle hsync, active high");
    chk("R2", vsync, 0, "idle vsync, active high");
    chk("R2", de, 1, "idle de, active low");
    set_en(1);
    step();
    chk("R6", hsync, 1, "hsync active high at line start");
    chk("R6", vsync, 1, "vsync active high at frame start");
    steps(135);
    report_mm("R6");
    set_en(0);
    wr(8, 4);
    steps(2);
  endtask

  task automatic t_stretch();
    begin_sc();
    wr(9, 161);
    steps(2);
    set_en(1);
    steps(137);
    chk("R8", hsync, 1, "no sync pulse inside stretched last line");
    chk("R8", vsync, 1, "vsync still idle in stretched last line");
    steps(3 * 161 - 137);
    report_mm("R8");
    chk("R8", period, 161, "stretched frame period");
    chk("R8", de_cnt, 96, "de clocks unchanged by stretch");
    set_en(0);
    steps(2);
  endtask

  task automatic t_nostretch();
    begin_sc();
    wr(9, 100);
    steps(2);
    set_en(1);
    steps(2 * 136);
    report_mm("R9");
    chk("R9", period, 136, "period with target below natural");
    set_en(0);
    begin_sc();
    wr(9, 136);
    steps(2);
    set_en(1);
    steps(2 * 136);
    chk("R9", period, 136, "period with target equal to natural");
    set_en(0);
    wr(9, 0);
    steps(2);
  endtask

  task automatic t_midwrite();
    begin_sc();
    set_en(1);
    steps(20);
    wr(0, 6);
    steps(136 - 21);
    chk("R10", de_cnt, 32, "de clocks of frame during write");
    de_cnt = 0;
    steps(120);
    chk("R10", de_cnt, 24, "de clocks of following frame");
    report_mm("R10");
    set_en(0);
    wr(0, 8);
    steps(2);
  endtask

  task automatic t_restart();
    begin_sc();
    set_en(1);
    steps(50);
    set_en(0);
    step();
    chk("R11", hsync, 1, "hsync idle after disable");
    chk("R11", vsync, 1, "vsync idle after disable");
    chk("R11", de, 0, "de idle after disable");
    chk("R11", pix_x + line_y, 0, "counters after disable");
    steps(4);
    set_en(1);
    step();
    chk("R11", hsync, 0, "hsync active at restart");
    chk("R11", vsync, 0, "vsync active at restart");
    steps(140);
    report_mm("R11");
    set_en(0);
    steps(2);
  endtask

  initial begin
    load_cfg();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_defaults();
    t_raster();
    t_polarity();
    t_stretch();
    t_nostretch();
    t_midwrite();
    t_restart();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule